// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is a 16-bit up-counting timer with a single channel. The channel runs either as edge-aligned PWM with high-true pulses or as an output-compare toggle. Software reaches it through a byte-wide write port. The period (modulo) and the channel threshold (compare) are 16 bits wide, so each takes two byte writes.

A byte write never reaches the active register directly. It lands in a staging buffer, and each buffer keeps a written flag per byte. A full buffer is copied into its active register only at a coherency point:

- While the clock select is zero, the counter is stopped and the copy happens as soon as both halves have arrived.
- While the counter runs, a modulo update waits for the step into the active modulo value.
- A PWM compare update waits for that same step.
- An output-compare update is taken on the next counter advance.

A modulo of zero means the counter is free-running over the full 16-bit range. A PWM output stays low until the first overflow after the clock is enabled.

Register addresses: 0 is the control byte (bits 4:3 clock select, nonzero means running; bits 2:0 prescale exponent). 1 and 2 are the modulo high and low bytes. 3 and 4 are the compare high and low bytes. 5 is the channel mode (bit 0: 0 = PWM, 1 = output compare).

Top module: `pwm_buffered_timer`

## Requirements
- R1: Writing one byte of the modulo or compare value leaves the corresponding active register unchanged until the other byte of that value has also been written.
- R2: With clock select 0, a buffer whose two bytes have both been written is copied to its active register on the clock edge after the completing write, and the counter holds its value.
- R3: With the counter running, a pending modulo value becomes active exactly on the counter step from (active modulo - 1) to the active modulo.
- R4: In output-compare mode (mode bit 0 = 1) with the counter running, a fully written compare value becomes active on the next counter advance after the completing write.
- R5: In PWM mode (mode bit 0 = 0) with the counter running, a pending compare value becomes active on the same step as a modulo update, the one into the active modulo value, and both bytes change together.
- R6: After the clock is enabled, the PWM output stays low until the counter's first wrap from the modulo value to 0; with clock select 0 the PWM output is low.
- R7: The counter advances once every 2^n input clocks, where n is the control prescale field (bits 2:0), and changes only by +1 or by wrapping.
- R8: A repeated write to the same byte of a buffer replaces that byte and does not complete the buffer.
- R9: An active modulo of 0 makes the counter free-running over 0..0xFFFF, and a pending modulo is then applied on the step from 0xFFFE to 0xFFFF.
- R10: In PWM mode, once started, the output is high exactly while the counter is below the active compare value: a compare of 0 gives constant low, and a compare above the modulo gives constant high.
- R11: The counter wraps from the active modulo to 0, and in output-compare mode the output toggles on the edge at which the counter reaches the active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Byte being written |
| cnt_o | output | 16 | Current counter value |
| mod_act_o | output | 16 | Active modulo register |
| cmp_act_o | output | 16 | Active compare register |
| ovf_o | output | 1 | Pulse on the counter wrap step |
| pwm_o | output | 1 | Channel output pin |

## Verification
The hardest situation to reach is the free-running update. It needs a zero modulo committed while the counter is stopped, then a second modulo written while the counter runs, then a wait of some 65,000 counts until the counter sits at 0xFFFE. The stimulus drives exactly that order and polls the counter at each falling edge, so it can check that the active modulo is still zero at 0xFFFE and has moved by 0xFFFF. The other running-mode transfers are caught the same way. The bench polls for the count just below the boundary and compares the active registers on that cycle and on the next.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;
  localparam int PSC_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_MOD_HI = 3'd1,
    A_MOD_LO = 3'd2,
    A_CMP_HI = 3'd3,
    A_CMP_LO = 3'd4,
    A_MODE   = 3'd5
  } addr_e;

  typedef struct packed {
    logic [1:0]       clk_sel;
    logic [PSC_W-1:0] psc;
  } ctrl_t;
endpackage

// File: rtl/pwmt_ctrl_regs.sv
module pwmt_ctrl_regs
  import pwmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output ctrl_t             ctrl_o,
  output logic              oc_mode_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_q, ctrl_d;
  logic  mode_q, mode_d;
  logic  unused_hi_bits;

  assign unused_hi_bits = ^wr_data[BYTE_W-1:CTRL_W];

  always_comb begin
    ctrl_d = ctrl_q;
    mode_d = mode_q;
    if (wr_en && wr_addr == A_CTRL) ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (wr_en && wr_addr == A_MODE) mode_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      mode_q <= mode_d;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign oc_mode_o = mode_q;
endmodule

// File: rtl/pwmt_wbuf.sv
module pwmt_wbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W/2-1:0] wr_byte,
  input  logic              load_en,
  output logic [DATA_W-1:0] act_o,
  output logic              full_o
);
  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0]   hi_q, hi_d, lo_q, lo_d;
  logic              fhi_q, fhi_d, flo_q, flo_d;
  logic [DATA_W-1:0] act_q, act_d;
  logic              commit;

  assign commit = load_en && fhi_q && flo_q;

  always_comb begin
    hi_d  = wr_hi ? wr_byte : hi_q;
    lo_d  = wr_lo ? wr_byte : lo_q;
    act_d = act_q;
    fhi_d = fhi_q | wr_hi;
    flo_d = flo_q | wr_lo;
    if (commit) begin
      act_d = {hi_q, lo_q};
      fhi_d = wr_hi;
      flo_d = wr_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      fhi_q <= 1'b0;
      flo_q <= 1'b0;
      act_q <= '0;
    end else begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      fhi_q <= fhi_d;
      flo_q <= flo_d;
      act_q <= act_d;
    end
  end

  assign act_o  = act_q;
  assign full_o = fhi_q && flo_q;
endmodule

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, term;

  assign term   = (DIV_W'(1) << psc) - DIV_W'(1);
  assign tick_o = en && (div_q >= term);

  always_comb begin
    div_d = div_q;
    if (en) div_d = tick_o ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] mod_act,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic [CNT_W-1:0] mod_eff_o,
  output logic             ovf_o,
  output logic             top_step_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, mod_eff;

  assign mod_eff    = (mod_act == '0) ? '1 : mod_act;
  assign ovf_o      = tick && (cnt_q == mod_eff);
  assign top_step_o = tick && (cnt_q == mod_eff - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = ovf_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign mod_eff_o = mod_eff;
endmodule

// File: rtl/pwm_buffered_timer.sv
module pwm_buffered_timer
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  mod_act_o,
  output logic [CNT_W-1:0]  cmp_act_o,
  output logic              ovf_o,
  output logic              pwm_o
);
  ctrl_t            ctrl;
  logic             oc_mode, clk_on, tick, top_step;
  logic             load_mod, load_cmp, mod_full, cmp_full;
  logic [CNT_W-1:0] cnt_nxt, mod_eff;
  logic             run_q, run_d, oc_q, oc_d;

  pwmt_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_o(ctrl), .oc_mode_o(oc_mode)
  );

  assign clk_on   = |ctrl.clk_sel;
  assign load_mod = clk_on ? top_step : 1'b1;
  assign load_cmp = !clk_on ? 1'b1 : (oc_mode ? tick : top_step);

  pwmt_wbuf #(.DATA_W(CNT_W)) u_mod_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_hi(wr_en && wr_addr == A_MOD_HI),
    .wr_lo(wr_en && wr_addr == A_MOD_LO),
    .wr_byte(wr_data), .load_en(load_mod),
    .act_o(mod_act_o), .full_o(mod_full)
  );

  pwmt_wbuf #(.DATA_W(CNT_W)) u_cmp_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_hi(wr_en && wr_addr == A_CMP_HI),
    .wr_lo(wr_en && wr_addr == A_CMP_LO),
    .wr_byte(wr_data), .load_en(load_cmp),
    .act_o(cmp_act_o), .full_o(cmp_full)
  );

  pwmt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(clk_on), .psc(ctrl.psc), .tick_o(tick)
  );

  pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mod_act(mod_act_o),
    .cnt_o(cnt_o), .cnt_nxt_o(cnt_nxt), .mod_eff_o(mod_eff),
    .ovf_o(ovf_o), .top_step_o(top_step)
  );

  always_comb begin
    run_d = run_q;
    if (!clk_on)    run_d = 1'b0;
    else if (ovf_o) run_d = 1'b1;
    oc_d = oc_q;
    if (tick && cnt_nxt == cmp_act_o) oc_d = ~oc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      oc_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      oc_q  <= oc_d;
    end
  end

  assign pwm_o = oc_mode ? oc_q : (run_q && (cnt_o < cmp_act_o));
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_on,
  input logic             oc_mode,
  input logic             tick,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] mod_eff,
  input logic [CNT_W-1:0] mod_act_o,
  input logic [CNT_W-1:0] cmp_act_o,
  input logic             pwm_o,
  input logic             mod_full,
  input logic             cmp_full
);
  logic unused_flags;
  assign unused_flags = mod_full ^ cmp_full;

  a_r11_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_o == mod_eff) |=> (cnt_o == '0));

  a_r7_step_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_o));

  a_r7_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_o == $past(cnt_o) + CNT_W'(1)) || (cnt_o == '0));

  a_r3_mod_swap_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    clk_on |=> $stable(mod_act_o) || (cnt_o == $past(mod_eff)));

  a_r5_cmp_swap_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_on && !oc_mode) |=> $stable(cmp_act_o) || (cnt_o == $past(mod_eff)));

  a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |=> $stable(cnt_o));

  a_r6_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_on && !oc_mode) |=> (oc_mode || !pwm_o));

  a_r10_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_mode && cmp_act_o == '0) |-> !pwm_o);
endmodule

bind pwm_buffered_timer pwmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_on(clk_on), .oc_mode(oc_mode),
  .tick(tick), .cnt_o(cnt_o), .mod_eff(mod_eff), .mod_act_o(mod_act_o),
  .cmp_act_o(cmp_act_o), .pwm_o(pwm_o), .mod_full(mod_full),
  .cmp_full(cmp_full)
);

// File: tb/pwm_buffered_timer_tb.sv
module pwm_buffered_timer_tb;
  logic        clk, rst_n, wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] cnt_o, mod_act_o, cmp_act_o;
  logic        ovf_o, pwm_o;
  int          n_vec, n_bad;

  pwm_buffered_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .mod_act_o(mod_act_o),
    .cmp_act_o(cmp_act_o), .ovf_o(ovf_o), .pwm_o(pwm_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    for (int i = 0; i < 70000; i++) begin
      if (cnt_o == v) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(cnt_o == 0 && mod_act_o == 0 && cmp_act_o == 0 && pwm_o == 0,
        "reset", {cnt_o, mod_act_o}, 0);
  endtask

  task automatic t_stopped_load;  // R1 R8 R2
    wr(3'd1, 8'h12);
    @(negedge clk);
    chk(mod_act_o == 16'h0, "R1 half written", mod_act_o, 0);
    wr(3'd1, 8'h00);
    @(negedge clk);
    chk(mod_act_o == 16'h0, "R8 same byte twice", mod_act_o, 0);
    wr(3'd2, 8'h09);
    @(negedge clk);
    chk(mod_act_o == 16'h0009, "R2 stopped modulo load", mod_act_o, 9);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h04);
    @(negedge clk);
    chk(cmp_act_o == 16'h0004, "R2 stopped compare load", cmp_act_o, 4);
    chk(cnt_o == 0, "R2 counter held", cnt_o, 0);
  endtask

  task automatic t_pwm_start;  // R6 R10
    bit ok;
    wr(3'd0, 8'h08);
    ok = 1;
    for (int i = 0; i < 10; i++) begin
      if (pwm_o) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R6 low before first wrap", pwm_o, 0);
    ok = 1;
    for (int i = 0; i < 10; i++) begin
      if (pwm_o != (cnt_o < 16'd4)) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R10 duty 4 of 10", pwm_o, 1);
  endtask

  task automatic t_run_mod;  // R3
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h0F);
    wait_cnt(16'd8);
    chk(mod_act_o == 16'd9, "R3 held before step", mod_act_o, 9);
    @(negedge clk);
    chk(cnt_o == 16'd9 && mod_act_o == 16'd15, "R3 applied on step", mod_act_o, 15);
    @(negedge clk);
    chk(cnt_o == 16'd10, "R3 new period in use", cnt_o, 10);
  endtask

  task automatic t_run_cmp_pwm;  // R5 R10
    bit ok;
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h07);
    wait_cnt(16'd14);
    chk(cmp_act_o == 16'd4, "R5 held before boundary", cmp_act_o, 4);
    @(negedge clk);
    chk(cnt_o == 16'd15 && cmp_act_o == 16'd7, "R5 applied at boundary", cmp_act_o, 7);
    ok = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (pwm_o != (cnt_o < 16'd7)) ok = 0;
    end
    chk(ok, "R10 duty 7 of 16", pwm_o, 0);
  endtask

  task automatic t_prescale;  // R7
    logic [15:0] c1;
    wr(3'd0, 8'h0A);
    @(negedge clk);
    c1 = cnt_o;
    repeat (8) @(negedge clk);
    chk(((cnt_o - c1) & 16'hF) == 16'd2, "R7 divide by 4", (cnt_o - c1) & 16'hF, 2);
    wr(3'd0, 8'h08);
  endtask

  task automatic t_oc;  // R4 R11
    logic p0;
    wr(3'd5, 8'h01);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h05);
    chk(cmp_act_o == 16'd7, "R4 not before advance", cmp_act_o, 7);
    @(negedge clk);
    chk(cmp_act_o == 16'd5, "R4 on next advance", cmp_act_o, 5);
    wait_cnt(16'd4);
    p0 = pwm_o;
    @(negedge clk);
    chk(cnt_o == 16'd5 && pwm_o == !p0, "R11 toggle on match", pwm_o, !p0);
    wait_cnt(16'd15);
    @(negedge clk);
    chk(cnt_o == 16'd0, "R11 wrap at modulo", cnt_o, 0);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_free_run;  // R9
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    @(negedge clk);
    wr(3'd0, 8'h08);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h05);
    wait_cnt(16'hFFFE);
    chk(cnt_o == 16'hFFFE && mod_act_o == 16'd0, "R9 free run held", mod_act_o, 0);
    @(negedge clk);
    chk(cnt_o == 16'hFFFF && mod_act_o == 16'd5, "R9 applied at top", mod_act_o, 5);
    @(negedge clk);
    chk(cnt_o == 16'd0, "R9 rolls to zero", cnt_o, 0);
  endtask

  task automatic t_duty_edges;  // R10
    bit ok;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00); wr(3'd2, 8'h09);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    wr(3'd0, 8'h08);
    repeat (12) @(negedge clk);
    ok = 1;
    for (int i = 0; i < 10; i++) begin
      if (pwm_o) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R10 compare 0 low", pwm_o, 0);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h00); wr(3'd4, 8'h0C);
    wr(3'd0, 8'h08);
    repeat (12) @(negedge clk);
    ok = 1;
    for (int i = 0; i < 10; i++) begin
      if (!pwm_o) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R10 compare above modulo high", pwm_o, 1);
  endtask

  initial begin
    #3800000;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopped_load();
    t_pwm_start();
    t_run_mod();
    t_run_cmp_pwm();
    t_prescale();
    t_oc();
    t_free_run();
    t_duty_edges();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule